// File: doc/BRIEF.md
# Voltage-Code Debounce Latch

This block sits between a processor that drives a 7-bit voltage-code bus together with a 2-bit rail-select bus, and two supply regulators (a core rail and an uncore rail). Both buses arrive with no relation to the local clock. They pass through a synchronizer and then a stability filter. Once the combined 9-bit value has held still for a programmable number of clock cycles, the block decodes the rail select. It then latches the code into the register of the addressed rail.

The two rails follow different update rules. The core rail follows every accepted code change for as long as it stays selected. The uncore rail takes a new code only when its select value is entered fresh after the bus has shown the invalid select. Nothing is sampled unless the regulator-enable input is high. A plain address/data strobe port lets a host preload boot codes before the processor takes over, and read back both latches.

Top module: `vid_latch_top`

## Requirements
- R1: The select encoding is 2'b00 invalid, 2'b01 core rail, 2'b10 uncore rail. The value 2'b11 is reserved: accepting it changes neither latch and raises no update strobe.
- R2: A new 9-bit {select, code} value is accepted only after it has been stable for STABLE_CYCLES synchronized samples (default 25, which is 200 ns at 125 MHz). Any change restarts the count. With the defaults, the latch and strobe change on the 29th rising edge after the inputs change. A value held for fewer cycles than the window changes nothing.
- R3: While select stays 2'b01, every accepted code change loads the core latch.
- R4: The uncore latch loads only on an accepted entry into 2'b10 after an accepted 2'b00. A code change while 2'b10 is held, or a re-entry via 2'b11, leaves it unchanged.
- R5: While reg_en_i is low, the code and select inputs change no latch and raise no strobe.
- R6: Both latches reset to 7'h7F. Read data bit 7 is always 0, and host write bit 7 is discarded.
- R7: Host port: host_addr_i 0 selects the core latch and 1 the uncore latch. A write happens on a clock edge with host_wr_i high. Read data is combinational from host_addr_i. Other addresses read 0 and ignore writes.
- R8: Each processor-driven load pulses that rail's update strobe for exactly one cycle, with the new code on that rail's code output.
- R9: When a host write and a processor load hit the same latch on the same edge, the processor code is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_en_i | input | 1 | Regulator enable; gates all bus sampling |
| code_i | input | 7 | Asynchronous voltage-code bus |
| rail_sel_i | input | 2 | Asynchronous rail-select bus |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data |
| core_upd_o | output | 1 | Core rail update strobe |
| core_code_o | output | 7 | Core rail latched code |
| uncore_upd_o | output | 1 | Uncore rail update strobe |
| uncore_code_o | output | 7 | Uncore rail latched code |

## Verification
A host write and a processor-driven load can reach the same latch on the same clock edge. The bench knows the exact filter latency. It drives a new core code, counts 28 rising edges, and raises the host write strobe so that it is sampled on the same edge as the filtered load. The check passes only if the latch holds the processor code and the core strobe pulses. A second case writes the uncore latch from the host on that same edge and expects both writes to take effect.

// File: rtl/vid_pkg.sv
package vid_pkg;

    localparam int VID_W     = 7;
    localparam int REG_W     = 8;
    localparam int NUM_RAILS = 2;
    localparam int WORD_W    = VID_W + 2;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'b00,
        SEL_CORE   = 2'b01,
        SEL_UNCORE = 2'b10,
        SEL_RSVD   = 2'b11
    } rail_sel_e;

    typedef struct packed {
        rail_sel_e          sel;
        logic [VID_W-1:0]   code;
    } vid_word_t;

    localparam logic [VID_W-1:0] VID_RESET  = '1;
    localparam vid_word_t        WORD_RESET = '{sel: SEL_NONE, code: VID_RESET};

    // rail index to select value (index 0 core, 1 uncore)
    function automatic rail_sel_e rail_sel_of(input int idx);
        return (idx == 0) ? SEL_CORE : SEL_UNCORE;
    endfunction

    // core-rail index tracks continuously, others need a fresh entry
    function automatic bit rail_tracks(input int idx);
        return idx == 0;
    endfunction

    function automatic logic [REG_W-1:0] to_reg(input logic [VID_W-1:0] c);
        return {1'b0, c};
    endfunction

endpackage

// File: rtl/vid_sync.sv
module vid_sync #(
    parameter int             W       = 9,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/vid_debounce.sv
module vid_debounce #(
    parameter int           W       = 9,
    parameter int           STABLE  = 25,
    parameter logic [W-1:0] RST_VAL = '0,
    localparam int          CNT_W   = $clog2(STABLE + 1)
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] word_o,
    output logic         stb_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE - 1);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(STABLE);

    logic [W-1:0]     prev_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= RST_VAL;
            cnt_q  <= '0;
            word_o <= RST_VAL;
            stb_o  <= 1'b0;
        end else begin
            stb_o <= 1'b0;
            if (!en_i) begin
                prev_q <= sample_i;
                cnt_q  <= '0;
            end else if (sample_i != prev_q) begin
                prev_q <= sample_i;
                cnt_q  <= '0;
            end else if (cnt_q < LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (cnt_q == LAST) begin
                cnt_q <= DONE;
                if (prev_q != word_o) begin
                    word_o <= prev_q;
                    stb_o  <= 1'b1;
                end
            end
        end
    end

    // R5: no acceptance follows a cycle with the enable low
    assert_no_accept_disabled_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !stb_o);

    // R2: the accepted word is the one that was sampled on the accepting edge
    assert_accept_is_sampled_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_o |-> word_o == $past(sample_i));

    // R8: an acceptance is a single-cycle event
    assert_accept_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_o |=> !stb_o);
endmodule

// File: rtl/vid_rail_latch.sv
module vid_rail_latch #(
    parameter bit                     TRACK   = 1'b1,
    parameter int                     W       = 7,
    parameter logic [W-1:0]           RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         stb_i,
    input  logic         hit_i,
    input  logic         none_i,
    input  logic [W-1:0] code_i,
    input  logic         host_wr_i,
    input  logic [W-1:0] host_code_i,
    output logic [W-1:0] code_o,
    output logic         upd_o
);
    logic take;

    if (TRACK) begin : g_track
        logic unused_none;
        assign unused_none = none_i;
        assign take        = stb_i && hit_i;
    end else begin : g_fresh
        logic armed_q;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                armed_q <= 1'b1;
            end else if (stb_i && none_i) begin
                armed_q <= 1'b1;
            end else if (stb_i && hit_i) begin
                armed_q <= 1'b0;
            end
        end
        assign take = stb_i && hit_i && armed_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            code_o <= RST_VAL;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= take;
            if (take) begin
                code_o <= code_i;
            end else if (host_wr_i) begin
                code_o <= host_code_i;
            end
        end
    end

    // R8: a strobe always shows the code that was accepted
    assert_upd_shows_code_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_o |-> code_o == $past(code_i));

    // R3/R4: a strobe only ever follows an acceptance addressed to this rail
    assert_upd_needs_hit_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_o |-> $past(stb_i && hit_i));
endmodule

// File: rtl/vid_latch_top.sv
module vid_latch_top
    import vid_pkg::*;
#(
    parameter int STABLE_CYCLES = 25,
    parameter int SYNC_STAGES   = 2,
    parameter int ADDR_W        = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              reg_en_i,
    input  logic [VID_W-1:0]  code_i,
    input  logic [1:0]        rail_sel_i,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [REG_W-1:0]  host_wdata_i,
    output logic [REG_W-1:0]  host_rdata_o,
    output logic              core_upd_o,
    output logic [VID_W-1:0]  core_code_o,
    output logic              uncore_upd_o,
    output logic [VID_W-1:0]  uncore_code_o
);
    logic [WORD_W-1:0] raw_bits, sync_bits, acc_bits;
    vid_word_t         acc_word;
    logic              acc_stb;
    logic              sel_none;
    logic              unused_rsvd;

    logic [VID_W-1:0]  rail_code [NUM_RAILS];
    logic              rail_upd  [NUM_RAILS];

    assign raw_bits    = {rail_sel_i, code_i};
    assign unused_rsvd = host_wdata_i[REG_W-1];

    vid_sync #(
        .W       (WORD_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (WORD_RESET)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_bits),
        .q_o   (sync_bits)
    );

    vid_debounce #(
        .W       (WORD_W),
        .STABLE  (STABLE_CYCLES),
        .RST_VAL (WORD_RESET)
    ) u_debounce (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (reg_en_i),
        .sample_i (sync_bits),
        .word_o   (acc_bits),
        .stb_o    (acc_stb)
    );

    assign acc_word = vid_word_t'(acc_bits);
    assign sel_none = (acc_word.sel == SEL_NONE);

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        logic hit;
        logic host_hit;
        assign hit      = (acc_word.sel == rail_sel_of(g));
        assign host_hit = host_wr_i && (host_addr_i == ADDR_W'(g));

        vid_rail_latch #(
            .TRACK   (rail_tracks(g)),
            .W       (VID_W),
            .RST_VAL (VID_RESET)
        ) u_latch (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .stb_i       (acc_stb),
            .hit_i       (hit),
            .none_i      (sel_none),
            .code_i      (acc_word.code),
            .host_wr_i   (host_hit),
            .host_code_i (host_wdata_i[VID_W-1:0]),
            .code_o      (rail_code[g]),
            .upd_o       (rail_upd[g])
        );
    end

    always_comb begin
        host_rdata_o = '0;
        for (int i = 0; i < NUM_RAILS; i++) begin
            if (host_addr_i == ADDR_W'(i)) begin
                host_rdata_o = to_reg(rail_code[i]);
            end
        end
    end

    assign core_upd_o    = rail_upd[0];
    assign core_code_o   = rail_code[0];
    assign uncore_upd_o  = rail_upd[1];
    assign uncore_code_o = rail_code[1];

    // R1: the reserved select never produces a rail update
    assert_rsvd_sel_ignored_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_stb && acc_word.sel == SEL_RSVD) |=> !(core_upd_o || uncore_upd_o));

    // R1: a single select value never addresses both rails
    assert_one_rail_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({core_upd_o, uncore_upd_o}));

    // R6: the reserved register bit always reads back as zero
    assert_rsvd_bit_zero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        host_rdata_o[REG_W-1] == 1'b0);
endmodule

// File: tb/vid_latch_top_tb.sv
module vid_latch_top_tb;
    localparam int STB = 25;
    localparam int LAT = STB + 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [6:0] code = 7'h7F;
    logic [1:0] sel = 2'b00;
    logic       hwr = 1'b0;
    logic [1:0] haddr = 2'd0;
    logic [7:0] hwdata = 8'h00;
    logic [7:0] hrdata;
    logic       cupd, uupd;
    logic [6:0] ccode, ucode;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    vid_latch_top #(.STABLE_CYCLES(STB)) u_dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .reg_en_i      (en),
        .code_i        (code),
        .rail_sel_i    (sel),
        .host_wr_i     (hwr),
        .host_addr_i   (haddr),
        .host_wdata_i  (hwdata),
        .host_rdata_o  (hrdata),
        .core_upd_o    (cupd),
        .core_code_o   (ccode),
        .uncore_upd_o  (uupd),
        .uncore_code_o (ucode)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        haddr = a;
        #1;
        d = hrdata;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        hwr = 1'b1; haddr = a; hwdata = d;
        @(negedge clk);
        hwr = 1'b0;
    endtask

    task automatic drive(input logic [1:0] s, input logic [6:0] c);
        @(negedge clk);
        sel = s; code = c;
    endtask

    task automatic settle(output int na, output int nb);
        na = 0; nb = 0;
        repeat (LAT + 4) begin
            @(negedge clk);
            na += int'(cupd);
            nb += int'(uupd);
        end
    endtask

    task automatic expect_rails(input string req, input logic [6:0] ea, input logic [6:0] eb,
                                input int na, input int nb, input int ena, input int enb);
        logic [7:0] d;
        check({req, " core code"}, int'(ccode), int'(ea));
        check({req, " uncore code"}, int'(ucode), int'(eb));
        check({req, " core strobes"}, na, ena);
        check({req, " uncore strobes"}, nb, enb);
        rd(2'd0, d);
        check({req, " core readback"}, int'(d), int'({1'b0, ea}));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] d;
        int na, nb;
        logic [6:0] a_exp, b_exp;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R6: reset values
        rd(2'd0, d); check("R6 reset core", int'(d), 8'h7F);
        rd(2'd1, d); check("R6 reset uncore", int'(d), 8'h7F);
        check("R8 reset strobes", int'({cupd, uupd}), 0);
        check("R6 reset outputs", int'({ccode, ucode}), 14'h3FFF);

        // R7/R6: host preload, bit 7 discarded, unmapped address inert
        host_write(2'd0, 8'hA5);
        host_write(2'd1, 8'h30);
        host_write(2'd2, 8'h11);
        rd(2'd0, d); check("R6 R7 core preload", int'(d), 8'h25);
        rd(2'd1, d); check("R7 uncore preload", int'(d), 8'h30);
        rd(2'd2, d); check("R7 unmapped read", int'(d), 0);
        rd(2'd3, d); check("R7 unmapped read 3", int'(d), 0);
        a_exp = 7'h25; b_exp = 7'h30;

        // R5: bus activity while disabled changes nothing
        drive(2'b01, 7'h05); settle(na, nb);
        expect_rails("R5 disabled core", a_exp, b_exp, na, nb, 0, 0);
        drive(2'b10, 7'h06); settle(na, nb);
        expect_rails("R5 disabled uncore", a_exp, b_exp, na, nb, 0, 0);
        drive(2'b00, 7'h7F); settle(na, nb);
        en = 1'b1;
        settle(na, nb);
        expect_rails("R5 enable on invalid", a_exp, b_exp, na, nb, 0, 0);

        // R2/R4/R8: exact latency on the uncore entry
        drive(2'b10, 7'h40);
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        check("R2 not before window", int'({uupd, ucode}), int'({1'b0, 7'h30}));
        @(negedge clk);
        check("R2 R4 R8 uncore load", int'({uupd, ucode}), int'({1'b1, 7'h40}));
        @(negedge clk);
        check("R8 strobe one cycle", int'(uupd), 0);
        b_exp = 7'h40;
        drive(2'b00, 7'h7F); settle(na, nb);
        expect_rails("R1 invalid select", a_exp, b_exp, na, nb, 0, 0);

        // R3: core tracks every code while 01 held, full sweep
        for (int c = 0; c < 128; c++) begin
            drive(2'b01, 7'(c)); settle(na, nb);
            a_exp = 7'(c);
            if (c == 127) begin
                expect_rails("R3 core sweep last", a_exp, b_exp, na, nb, 1, 0);
            end else begin
                check("R3 core sweep", int'(ccode), c);
                check("R3 R8 core sweep strobe", na, 1);
                check("R3 uncore untouched", int'(ucode), int'(b_exp));
            end
        end

        // R2: a glitch shorter than the window is dropped
        drive(2'b01, 7'h12);
        repeat (STB - 5) @(negedge clk);
        code = 7'h7F;
        settle(na, nb);
        expect_rails("R2 short glitch", a_exp, b_exp, na, nb, 0, 0);

        // R4: fresh entry loads, held select ignores code changes
        drive(2'b00, 7'h00); settle(na, nb);
        drive(2'b10, 7'h11); settle(na, nb);
        b_exp = 7'h11;
        expect_rails("R4 fresh entry", a_exp, b_exp, na, nb, 0, 1);
        drive(2'b10, 7'h12); settle(na, nb);
        expect_rails("R4 held code change", a_exp, b_exp, na, nb, 0, 0);

        // R1: reserved select with a new code is ignored; re-entry through it too
        drive(2'b11, 7'h55); settle(na, nb);
        expect_rails("R1 reserved select", a_exp, b_exp, na, nb, 0, 0);
        drive(2'b10, 7'h13); settle(na, nb);
        expect_rails("R4 reentry via reserved", a_exp, b_exp, na, nb, 0, 0);

        // R4: uncore sweep with an invalid phase between codes
        for (int k = 0; k < 16; k++) begin
            drive(2'b00, 7'h00); settle(na, nb);
            drive(2'b10, 7'(k * 8 + 3)); settle(na, nb);
            b_exp = 7'(k * 8 + 3);
            check("R4 uncore sweep", int'(ucode), int'(b_exp));
            check("R4 R8 uncore sweep strobe", nb, 1);
            rd(2'd1, d);
            check("R4 R7 uncore readback", int'(d), int'({1'b0, b_exp}));
        end

        // R9: host write and core load on the same edge
        drive(2'b00, 7'h00); settle(na, nb);
        drive(2'b01, 7'h6A);
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        hwr = 1'b1; haddr = 2'd0; hwdata = 8'h15;
        @(negedge clk);
        hwr = 1'b0;
        check("R9 collision strobe", int'(cupd), 1);
        check("R9 processor wins", int'(ccode), 8'h6A);
        a_exp = 7'h6A;

        // R9: same-edge writes to different rails both land
        drive(2'b01, 7'h2B);
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        hwr = 1'b1; haddr = 2'd1; hwdata = 8'h9C;
        @(negedge clk);
        hwr = 1'b0;
        check("R9 core still loads", int'(ccode), 8'h2B);
        check("R9 other rail host write", int'(ucode), 8'h1C);
        a_exp = 7'h2B; b_exp = 7'h1C;

        // R7: host write alone on the core rail
        host_write(2'd0, 8'h15);
        rd(2'd0, d); check("R7 host write core", int'(d), 8'h15);
        a_exp = 7'h15;

        // R5: disable again after activity
        en = 1'b0;
        drive(2'b01, 7'h44); settle(na, nb);
        expect_rails("R5 disabled later", a_exp, b_exp, na, nb, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule